// File: doc/BRIEF.md
# SCL Rate Generator

This block produces the serial clock for a two-wire bus master. A protocol engine raises `run` while it is transferring, and the generator then alternates low and high phases on SCL. It pulls the line low by asserting `scl_drive` and releases it by deasserting it. Each phase is timed in reference ticks. A selectable prescaler derives those ticks from the system clock by dividing it by a power of two. Each phase lasts a programmed count plus a fixed number of ticks that covers the input synchronizer and the noise filter.

The high phase does not start counting when the generator releases the line. It starts once the line, sampled through a two-stage synchronizer, is actually seen high. A slow rising edge, or a target that holds the clock low, therefore lengthens the period without breaking the timing. One-cycle strobes mark the middle of each phase so that the engine can shift data out during low and sample it during high. A small register file holds the prescaler select, the two phase counts and a fast-mode-plus enable bit. That bit is exported as `fmp_en` for the pad logic.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset `scl_drive`, `strobe_lo`, `strobe_hi` and `fmp_en` are 0, the divider register reads 0x00, the low and high count registers read 0xE1, and the mode register reads 0x00.
- R2: While `run` is 0 the line is released; one cycle after `run` falls `scl_drive` is 0 and stays 0. One cycle after `run` rises, a period begins with a low phase.
- R3: With prescaler select 0, a low phase lasts (low count + 4) clock cycles.
- R4: A high phase counts only once the line, sampled through two flops, reads high. With an immediate loopback and prescaler select 0 it therefore lasts 2 + (high count + 4) cycles.
- R5: With prescaler select k from 1 to 7, one tick is 2^k cycles and each phase counts (count + 3) ticks. The low phase lasts (low count + 3)·2^k cycles, and the high phase lasts 2 + (high count + 3)·2^k cycles under loopback.
- R6: If the line is held low for D cycles after release, the high phase grows by exactly D cycles.
- R7: For a phase of N ticks, the strobe of that phase pulses for one cycle at tick floor(N/2), counting from 0. This is cycle (floor(N/2)+1)·2^k − 1 after the low phase starts, or after the line is first seen high in the high phase.
- R8: The register map is address 0 for the divider (prescaler select in bits 2:0, unlock key in bit 3, which reads 0), address 1 for the low count, address 2 for the high count and address 3 for the mode (fast-mode-plus in bit 0). The counts occupy bits 4:0, and bits 7:5 always read 1.
- R9: A write to address 0 changes the prescaler select only when bit 3 of the same write is 1. Otherwise the select keeps its value.
- R10: Writing 0 to a count register stores 1, the smallest usable count.
- R11: The fast-mode-plus bit drives `fmp_en` directly and reads back at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Transfer request from the protocol engine |
| scl_in | input | 1 | Sampled SCL line level |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data at `cfg_addr` |
| scl_drive | output | 1 | 1 pulls SCL low, 0 releases it |
| strobe_lo | output | 1 | Middle of low phase |
| strobe_hi | output | 1 | Middle of counted high phase |
| fmp_en | output | 1 | Fast-mode-plus enable |

## Verification
The hardest situation to reach is a high phase that is held low from outside while a non-bypassed prescaler is running. In that case the tick divider must restart once the line rises, or the length drifts by a fraction of a tick. The bench models the bus with a loopback gate on `scl_in` that can be forced low for a chosen number of cycles after release. It measures phase lengths and strobe positions at the ports with divide ratios 1, 4 and 128, with and without stretching.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_e;

   localparam logic [1:0] ADDR_DIV  = 2'd0;
   localparam logic [1:0] ADDR_LOW  = 2'd1;
   localparam logic [1:0] ADDR_HIGH = 2'd2;
   localparam logic [1:0] ADDR_MODE = 2'd3;
endpackage

// File: rtl/sclgen_regs.sv
module sclgen_regs
   import sclgen_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int CNT_W   = 5,
   parameter int PS_W    = 3,
   parameter int KEY_BIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic [PS_W-1:0]   ps_sel,
   output logic [CNT_W-1:0]  lo_cnt,
   output logic [CNT_W-1:0]  hi_cnt,
   output logic              fmp_q
);
   localparam int RSV_W = DATA_W - CNT_W;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (CNT_W >= DATA_W) begin : g_bad_cnt
      $error("CNT_W must leave reserved bits in the data word");
   end
   if (KEY_BIT < PS_W || KEY_BIT >= DATA_W) begin : g_bad_key
      $error("KEY_BIT must lie above the prescaler field");
   end

   logic [CNT_W-1:0] wcnt;
   logic             unused_wdata;

   assign wcnt         = (cfg_wdata[CNT_W-1:0] == '0) ? CNT_ONE : cfg_wdata[CNT_W-1:0];
   assign unused_wdata = ^cfg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_sel <= '0;
         lo_cnt <= CNT_ONE;
         hi_cnt <= CNT_ONE;
         fmp_q  <= 1'b0;
      end else if (cfg_we) begin
         case (cfg_addr)
            ADDR_DIV:  if (cfg_wdata[KEY_BIT]) ps_sel <= cfg_wdata[PS_W-1:0];
            ADDR_LOW:  lo_cnt <= wcnt;
            ADDR_HIGH: hi_cnt <= wcnt;
            default:   fmp_q  <= cfg_wdata[0];
         endcase
      end
   end

   always_comb begin
      case (cfg_addr)
         ADDR_DIV:  cfg_rdata = {{(DATA_W-PS_W){1'b0}}, ps_sel};
         ADDR_LOW:  cfg_rdata = {{RSV_W{1'b1}}, lo_cnt};
         ADDR_HIGH: cfg_rdata = {{RSV_W{1'b1}}, hi_cnt};
         default:   cfg_rdata = {{(DATA_W-1){1'b0}}, fmp_q};
      endcase
   end

   // R9
   wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == ADDR_DIV && !cfg_wdata[KEY_BIT]) |=> $stable(ps_sel));
endmodule

// File: rtl/sclgen_prescaler.sv
module sclgen_prescaler #(
   parameter int PS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic [PS_W-1:0] ps_sel,
   output logic            tick
);
   localparam int DIV_W = (1 << PS_W) - 1;

   if (PS_W < 1 || PS_W > 4) begin : g_bad_ps
      $error("PS_W out of supported range");
   end

   logic [DIV_W-1:0] pdiv;
   logic [DIV_W-1:0] mask;

   assign mask = ~({DIV_W{1'b1}} << ps_sel);
   assign tick = !clr && ((pdiv & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pdiv <= '0;
      else if (clr) pdiv <= '0;
      else          pdiv <= pdiv + 1'b1;
   end

   // R5
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ps_sel != '0) |=> (!tick || ps_sel == '0));
endmodule

// File: rtl/sclgen_sync.sv
module sclgen_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("synchronizer needs at least two stages");
   end

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= {STAGES{RST_VAL}};
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase
   import sclgen_pkg::*;
#(
   parameter int CNT_W   = 5,
   parameter int PS_W    = 3,
   parameter int OVH_BYP = 4,
   parameter int OVH_DIV = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             scl_s,
   input  logic [PS_W-1:0]  ps_sel,
   input  logic [CNT_W-1:0] lo_cnt,
   input  logic [CNT_W-1:0] hi_cnt,
   output phase_e           ph,
   output logic             presc_clr,
   output logic             strobe_lo,
   output logic             strobe_hi
);
   localparam int LEN_W = $clog2((1 << CNT_W) + OVH_BYP + 1);

   if (OVH_BYP < 1 || OVH_DIV < 1) begin : g_bad_ovh
      $error("overhead counts must be positive");
   end

   logic [LEN_W-1:0] ovh, len_lo, len_hi, len_cur, half, cnt;
   logic             adv, last;

   assign ovh     = (ps_sel == '0) ? LEN_W'(OVH_BYP) : LEN_W'(OVH_DIV);
   assign len_lo  = LEN_W'(lo_cnt) + ovh;
   assign len_hi  = LEN_W'(hi_cnt) + ovh;
   assign len_cur = (ph == PH_HIGH) ? len_hi : len_lo;
   assign half    = len_cur >> 1;
   assign last    = cnt >= (len_cur - LEN_W'(1));

   assign adv       = tick && ((ph == PH_LOW) || (ph == PH_HIGH && scl_s));
   assign presc_clr = (ph == PH_IDLE) || (ph == PH_HIGH && !scl_s);
   assign strobe_lo = (ph == PH_LOW)  && adv && (cnt == half);
   assign strobe_hi = (ph == PH_HIGH) && adv && (cnt == half);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else if (!run) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else begin
         case (ph)
            PH_IDLE: begin
               ph  <= PH_LOW;
               cnt <= '0;
            end
            PH_LOW: if (adv) begin
               if (last) begin
                  ph  <= PH_HIGH;
                  cnt <= '0;
               end else cnt <= cnt + 1'b1;
            end
            PH_HIGH: if (adv) begin
               if (last) begin
                  ph  <= PH_LOW;
                  cnt <= '0;
               end else cnt <= cnt + 1'b1;
            end
            default: begin
               ph  <= PH_IDLE;
               cnt <= '0;
            end
         endcase
      end
   end

   // R6
   stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_HIGH && !scl_s && run) |=> $stable(cnt));
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
   import sclgen_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 5,
   parameter int PS_W        = 3,
   parameter int KEY_BIT     = 3,
   parameter int SYNC_STAGES = 2,
   parameter int OVH_BYP     = 4,
   parameter int OVH_DIV     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              scl_in,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              scl_drive,
   output logic              strobe_lo,
   output logic              strobe_hi,
   output logic              fmp_en
);
   logic [PS_W-1:0]  ps_sel;
   logic [CNT_W-1:0] lo_cnt, hi_cnt;
   logic             tick, presc_clr, scl_s;
   phase_e           ph;

   sclgen_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PS_W(PS_W), .KEY_BIT(KEY_BIT)) regs_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ps_sel(ps_sel),
      .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .fmp_q(fmp_en));

   sclgen_prescaler #(.PS_W(PS_W)) presc_i (
      .clk(clk), .rst_n(rst_n), .clr(presc_clr), .ps_sel(ps_sel), .tick(tick));

   sclgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));

   sclgen_phase #(.CNT_W(CNT_W), .PS_W(PS_W), .OVH_BYP(OVH_BYP), .OVH_DIV(OVH_DIV)) phase_i (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .scl_s(scl_s),
      .ps_sel(ps_sel), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .ph(ph),
      .presc_clr(presc_clr), .strobe_lo(strobe_lo), .strobe_hi(strobe_hi));

   assign scl_drive = (ph == PH_LOW);

   // R2
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !scl_drive);

   // R7
   strobe_lo_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_lo |-> scl_drive);

   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({strobe_lo, strobe_hi}));
endmodule

// File: tb/scl_rate_gen_tb_top.sv
module scl_rate_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic       stretch = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_addr = 2'd0;
   logic [7:0] cfg_wdata = 8'd0;
   logic [7:0] cfg_rdata;
   logic       scl_drive, strobe_lo, strobe_hi, fmp_en, scl_in;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign scl_in = !scl_drive && !stretch;

   scl_rate_gen dut_i (
      .clk(clk), .rst_n(rst_n), .run(run), .scl_in(scl_in),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .scl_drive(scl_drive), .strobe_lo(strobe_lo),
      .strobe_hi(strobe_hi), .fmp_en(fmp_en));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_check(input logic [1:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      cfg_addr = a;
      #1;
      check(cfg_rdata == exp, req, cfg_rdata, exp);
   endtask

   function automatic int ticks(input int ps, input int cnt);
      return ((cnt == 0) ? 1 : cnt) + ((ps == 0) ? 4 : 3);
   endfunction

   function automatic int strobe_at(input int ps, input int cnt);
      return (((ticks(ps, cnt) >> 1) + 1) << ps) - 1;
   endfunction

   task automatic measure(input int d, output int lo_len, output int hi_len,
                          output int lo_st, output int hi_st);
      int n;
      stretch = (d > 0);
      @(negedge clk);
      run = 1'b1;
      @(negedge clk);
      while (!scl_drive) @(negedge clk);
      n = 0; lo_st = -1;
      while (scl_drive) begin
         if (strobe_lo) lo_st = n;
         n++;
         @(negedge clk);
      end
      lo_len = n;
      n = 0; hi_st = -1;
      while (!scl_drive) begin
         if (n == d) stretch = 1'b0;
         if (strobe_hi) hi_st = n;
         n++;
         @(negedge clk);
      end
      hi_len = n;
      run = 1'b0;
      @(negedge clk);
      check(!scl_drive, "R2 release after run falls", scl_drive, 0);
   endtask

   task automatic period_test(input int ps, input int lo, input int hi, input int d,
                              input string rlo, input string rhi);
      int ll, hl, ls, hs;
      wr(2'd0, 8'h08 | 8'(ps));
      wr(2'd1, 8'(lo));
      wr(2'd2, 8'(hi));
      measure(d, ll, hl, ls, hs);
      check(ll == (ticks(ps, lo) << ps), rlo, ll, ticks(ps, lo) << ps);
      check(hl == d + 2 + (ticks(ps, hi) << ps), rhi, hl, d + 2 + (ticks(ps, hi) << ps));
      check(ls == strobe_at(ps, lo), "R7 low strobe", ls, strobe_at(ps, lo));
      check(hs == d + 2 + strobe_at(ps, hi), "R7 high strobe", hs, d + 2 + strobe_at(ps, hi));
   endtask

   task automatic t_reset;
      check(!scl_drive && !strobe_lo && !strobe_hi, "R1 outputs", scl_drive, 0);
      check(!fmp_en, "R1 fmp_en", fmp_en, 0);
      rd_check(2'd0, 8'h00, "R1 divider");
      rd_check(2'd1, 8'hE1, "R1 low count");
      rd_check(2'd2, 8'hE1, "R1 high count");
      rd_check(2'd3, 8'h00, "R1 mode");
   endtask

   task automatic t_idle;
      int seen = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (scl_drive) seen++;
      end
      check(seen == 0, "R2 idle without run", seen, 0);
      @(negedge clk);
      run = 1'b1;
      @(negedge clk);
      check(scl_drive, "R2 starts with low", scl_drive, 1);
      run = 1'b0;
      @(negedge clk);
      check(!scl_drive, "R2 release", scl_drive, 0);
   endtask

   task automatic t_regs;
      wr(2'd0, 8'h05);
      rd_check(2'd0, 8'h00, "R9 select locked without key");
      wr(2'd0, 8'h0D);
      rd_check(2'd0, 8'h05, "R9 select written with key");
      wr(2'd0, 8'h02);
      rd_check(2'd0, 8'h05, "R9 select held");
      wr(2'd1, 8'h15);
      rd_check(2'd1, 8'hF5, "R8 low reserved bits");
      wr(2'd2, 8'h1F);
      rd_check(2'd2, 8'hFF, "R8 high max");
      wr(2'd1, 8'h00);
      rd_check(2'd1, 8'hE1, "R10 low zero stored as one");
      wr(2'd2, 8'hE0);
      rd_check(2'd2, 8'hE1, "R10 high zero stored as one");
      wr(2'd3, 8'h01);
      rd_check(2'd3, 8'h01, "R11 mode readback");
      check(fmp_en, "R11 fmp_en set", fmp_en, 1);
      wr(2'd3, 8'h00);
      check(!fmp_en, "R11 fmp_en clear", fmp_en, 0);
      wr(2'd0, 8'h08);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle();
      t_regs();
      period_test(0, 5, 7, 0, "R3 low bypass", "R4 high bypass");
      period_test(0, 0, 0, 0, "R3 low minimum", "R4 high minimum");
      period_test(0, 31, 31, 0, "R3 low max", "R4 high max");
      period_test(2, 2, 4, 0, "R5 low div4", "R5 high div4");
      period_test(7, 31, 1, 0, "R5 low div128", "R5 high div128");
      period_test(0, 3, 6, 6, "R3 low", "R6 stretched high");
      period_test(1, 4, 2, 9, "R5 low div2", "R6 stretched high div2");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog: actual %0d cycles expected completion", WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule